// File: doc/BRIEF.md
# EEPROM Boot Configuration Sequencer

After a device reset, this block fills the device's configuration register space from a serial EEPROM. It controls a read-only serial-bus master through a simple burst-read request. The master returns one byte per strobe, or it signals that the EEPROM did not acknowledge. The sequencer copies each byte of the image into the register file through a write port. It also runs a CRC-8 over the image and compares the result with the checksum byte stored at the end of the image.

A boot has two phases. The first is a short read at the slow bus rate. It fetches the byte that holds the rate-select bit. The second reads the whole image at the rate that bit selects. If the EEPROM does not acknowledge, or the checksum does not match, the sequencer starts again from the first phase. It retries a bounded number of times. After that it aborts, raises an error flag and holds the bus lines low until software clears the flag. While a boot is pending or running, the block tells the host port to refuse register accesses.

Top module: `eeprom_boot_seq`

## Requirements
- R1: After reset the block issues no read request until both `boot_en` and `cal_done` are high. While `boot_en` is high and the boot has not finished, `host_busy` is 1. While `boot_en` is low in the idle state, `host_busy` is 0.
- R2: Each attempt starts with a speed-phase request with `rd_addr`=0, `rd_cnt`=2 and `rd_fast`=0.
- R3: The image-phase request has `rd_addr`=0 and `rd_cnt`=927, so it covers offsets 0x000..0x39E. Its `rd_fast` equals bit 7 of the byte at offset 0x001 from the speed phase: 0 selects the slow rate and 1 the fast rate.
- R4: Every image-phase byte is written once through `reg_we`/`reg_addr`/`reg_wdata`. The write address equals the byte's offset in the image.
- R5: The checksum is CRC-8 with polynomial 0x07. It is processed MSB first, with initial value 0x00, no reflection and no final XOR. It covers offsets 0x000..0x39D in order and is compared with the byte at offset 0x39E.
- R6: A NACK in either phase, or a checksum mismatch, restarts the boot with a new speed-phase request.
- R7: At most three restarts follow the first attempt. When the fourth attempt fails, `err_irq` is set, `done_irq` stays 0 and no further read request is issued.
- R8: While `err_irq` is 1, `bus_force_low` is 1. A pulse on `err_clr` clears both, and no new boot starts.
- R9: A successful attempt sets `done_irq`, leaves `err_irq` and `bus_force_low` at 0, and no further read request is issued.
- R10: `host_busy` is 1 for every byte delivered during a boot. It is 0 once `done_irq` or `err_irq` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high device reset |
| boot_en | input | 1 | Boot-from-EEPROM mode selected |
| cal_done | input | 1 | Internal calibration finished |
| err_clr | input | 1 | Clears the read-error flag |
| rd_req | output | 1 | One-cycle burst-read request to the bus master |
| rd_addr | output | 10 | First EEPROM offset of the burst |
| rd_cnt | output | 11 | Number of bytes in the burst |
| rd_fast | output | 1 | Bus rate for the burst: 0 slow, 1 fast |
| rd_vld | input | 1 | Byte strobe from the bus master |
| rd_byte | input | 8 | Byte returned by the bus master |
| rd_nack | input | 1 | EEPROM did not acknowledge; the burst ends |
| reg_we | output | 1 | Register-file write strobe |
| reg_addr | output | 10 | Register-file write address |
| reg_wdata | output | 8 | Register-file write data |
| host_busy | output | 1 | Host register accesses must not be serviced |
| done_irq | output | 1 | Boot completed |
| err_irq | output | 1 | Boot aborted after the retry limit |
| bus_force_low | output | 1 | Request to hold the bus clock and data lines low |

## Verification
The hardest state to reach is the exact boundary of the retry budget. The test must show that three failed attempts still lead to a good boot, while four failed attempts abort. The bench model of the bus master takes a failure plan for each attempt. A plan can be a NACK in the speed phase, a NACK at a random byte of the image, or a corrupted checksum byte. The bench mixes these across the four attempts and checks the attempt count, the final flags and the register contents after the last attempt. The images are random, with zero-filled stretches and both values of the rate bit.

// File: rtl/boot_pkg.sv
package boot_pkg;

    localparam int unsigned BOOT_ADDR_W   = 10;
    localparam int unsigned BOOT_CRC_OFS  = 'h39E;
    localparam int unsigned BOOT_SPD_OFS  = 1;
    localparam int unsigned BOOT_SPD_BIT  = 7;
    localparam int unsigned BOOT_RETRIES  = 3;
    localparam logic [7:0]  BOOT_CRC_POLY = 8'h07;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SPD_REQ,
        ST_SPD_RX,
        ST_IMG_REQ,
        ST_IMG_RX,
        ST_FAIL,
        ST_ABORT,
        ST_DONE,
        ST_HALT
    } boot_st_e;

    typedef struct packed {
        logic       we;
        logic [7:0] data;
    } wr_beat_t;

    // One byte through a CRC-8, MSB first, no reflection.
    function automatic logic [7:0] crc8_step(input logic [7:0] crc,
                                             input logic [7:0] din,
                                             input logic [7:0] poly);
        logic [7:0] c;
        c = crc ^ din;
        for (int b = 0; b < 8; b++) begin
            c = c[7] ? ((c << 1) ^ poly) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/boot_crc8.sv
module boot_crc8
    import boot_pkg::*;
#(
    parameter logic [7:0] POLY = BOOT_CRC_POLY
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       upd,
    input  logic [7:0] din,
    output logic [7:0] crc
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc <= 8'h00;
        end else if (upd) begin
            crc <= crc8_step(crc, din, POLY);
        end
    end

    // R5: every attempt begins from a zero checksum
    a_r5_clear_to_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> (crc == 8'h00));

endmodule

// File: rtl/boot_retry.sv
module boot_retry
    import boot_pkg::*;
#(
    parameter int unsigned MAX_RETRY = BOOT_RETRIES
) (
    input  logic clk,
    input  logic rst,
    input  logic fail,
    output logic spent
);

    localparam int unsigned CW = (MAX_RETRY < 2) ? 1 : $clog2(MAX_RETRY + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_RETRY);

    logic [CW-1:0] used;

    assign spent = (used == LIMIT);

    // Only a device reset returns the budget; attempts do not.
    always_ff @(posedge clk) begin
        if (rst) begin
            used <= '0;
        end else if (fail && !spent) begin
            used <= used + 1'b1;
        end
    end

    // R7: an exhausted budget stays exhausted until reset
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
        spent |=> spent);

endmodule

// File: rtl/boot_idx.sv
module boot_idx #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] idx
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx <= '0;
        end else if (inc) begin
            idx <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/eeprom_boot_seq.sv
module eeprom_boot_seq
    import boot_pkg::*;
#(
    parameter int unsigned ADDR_W    = BOOT_ADDR_W,
    parameter int unsigned CRC_OFS   = BOOT_CRC_OFS,
    parameter int unsigned SPD_OFS   = BOOT_SPD_OFS,
    parameter int unsigned SPD_BIT   = BOOT_SPD_BIT,
    parameter int unsigned MAX_RETRY = BOOT_RETRIES,
    parameter logic [7:0]  POLY      = BOOT_CRC_POLY
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_en,
    input  logic              cal_done,
    input  logic              err_clr,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W:0]   rd_cnt,
    output logic              rd_fast,
    input  logic              rd_vld,
    input  logic [7:0]        rd_byte,
    input  logic              rd_nack,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [7:0]        reg_wdata,
    output logic              host_busy,
    output logic              done_irq,
    output logic              err_irq,
    output logic              bus_force_low
);

    localparam int unsigned CNT_W = ADDR_W + 1;
    localparam logic [ADDR_W-1:0] LAST_OFS = ADDR_W'(CRC_OFS);
    localparam logic [ADDR_W-1:0] RATE_OFS = ADDR_W'(SPD_OFS);
    localparam logic [CNT_W-1:0]  SPD_LEN  = CNT_W'(SPD_OFS + 1);
    localparam logic [CNT_W-1:0]  IMG_LEN  = CNT_W'(CRC_OFS + 1);

    boot_st_e          st, st_nx;
    logic [ADDR_W-1:0] idx;
    logic [7:0]        crc;
    logic              fast_q;
    logic              spent;
    logic              byte_ok;
    logic              at_last;
    logic              crc_match;
    wr_beat_t          beat;

    assign byte_ok   = rd_vld && !rd_nack;
    assign at_last   = (idx == LAST_OFS);
    assign crc_match = (crc == rd_byte);

    boot_idx #(.W(ADDR_W)) u_idx (
        .clk (clk),
        .rst (rst),
        .clr (st == ST_SPD_REQ || st == ST_IMG_REQ),
        .inc (byte_ok && (st == ST_SPD_RX || st == ST_IMG_RX)),
        .idx (idx)
    );

    boot_crc8 #(.POLY(POLY)) u_crc (
        .clk (clk),
        .rst (rst),
        .clr (st == ST_SPD_REQ),
        .upd (byte_ok && st == ST_IMG_RX && !at_last),
        .din (rd_byte),
        .crc (crc)
    );

    boot_retry #(.MAX_RETRY(MAX_RETRY)) u_retry (
        .clk   (clk),
        .rst   (rst),
        .fail  (st == ST_FAIL),
        .spent (spent)
    );

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:    if (boot_en && cal_done) st_nx = ST_SPD_REQ;
            ST_SPD_REQ: st_nx = ST_SPD_RX;
            ST_SPD_RX: begin
                if (rd_nack)                          st_nx = ST_FAIL;
                else if (rd_vld && idx == RATE_OFS)   st_nx = ST_IMG_REQ;
            end
            ST_IMG_REQ: st_nx = ST_IMG_RX;
            ST_IMG_RX: begin
                if (rd_nack)                  st_nx = ST_FAIL;
                else if (rd_vld && at_last)   st_nx = crc_match ? ST_DONE : ST_FAIL;
            end
            ST_FAIL:    st_nx = spent ? ST_ABORT : ST_SPD_REQ;
            ST_ABORT:   if (err_clr) st_nx = ST_HALT;
            ST_DONE:    st_nx = ST_DONE;
            ST_HALT:    st_nx = ST_HALT;
            default:    st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            fast_q   <= 1'b0;
            done_irq <= 1'b0;
            err_irq  <= 1'b0;
        end else begin
            st <= st_nx;
            if (st == ST_SPD_RX && byte_ok && idx == RATE_OFS) begin
                fast_q <= rd_byte[SPD_BIT];
            end
            if (st != ST_DONE && st_nx == ST_DONE) begin
                done_irq <= 1'b1;
            end
            if (st == ST_FAIL && st_nx == ST_ABORT) begin
                err_irq <= 1'b1;
            end else if (st == ST_ABORT && err_clr) begin
                err_irq <= 1'b0;
            end
        end
    end

    // Registered write port toward the register file.
    always_ff @(posedge clk) begin
        if (rst) begin
            beat     <= '0;
            reg_addr <= '0;
        end else begin
            beat.we   <= byte_ok && st == ST_IMG_RX;
            beat.data <= rd_byte;
            reg_addr  <= idx;
        end
    end

    assign reg_we    = beat.we;
    assign reg_wdata = beat.data;

    assign rd_req  = (st == ST_SPD_REQ) || (st == ST_IMG_REQ);
    assign rd_addr = '0;
    assign rd_cnt  = (st == ST_IMG_REQ) ? IMG_LEN : SPD_LEN;
    assign rd_fast = (st == ST_IMG_REQ) && fast_q;

    assign host_busy = (st == ST_IDLE && boot_en) || st == ST_SPD_REQ ||
                       st == ST_SPD_RX || st == ST_IMG_REQ ||
                       st == ST_IMG_RX || st == ST_FAIL;

    assign bus_force_low = err_irq;

    // R2: the speed phase always runs at the slow rate
    a_r2_speed_slow: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_cnt == SPD_LEN) |-> !rd_fast);

    // R7: once aborted, the master is never asked to read again
    a_r7_no_req_after_abort: assert property (@(posedge clk) disable iff (rst)
        err_irq |-> !rd_req);

    // R8: the error flag only falls on a clear request
    a_r8_err_clear_only: assert property (@(posedge clk) disable iff (rst)
        $fell(err_irq) |-> $past(err_clr));

    // R9: success and abort never coexist
    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done_irq && err_irq));

    // R9: after success no read request follows
    a_r9_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
        done_irq |-> !rd_req);

    // R10: the host is released once the boot has finished
    a_r10_host_free: assert property (@(posedge clk) disable iff (rst)
        (done_irq || err_irq) |-> !host_busy);

endmodule

// File: tb/tb_eeprom_boot_seq.sv
module tb_eeprom_boot_seq;

    localparam int IMG_N   = 927;
    localparam int CRC_OFS = 'h39E;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boot_en = 1'b0;
    logic        cal_done = 1'b0;
    logic        err_clr = 1'b0;
    logic        rd_req;
    logic [9:0]  rd_addr;
    logic [10:0] rd_cnt;
    logic        rd_fast;
    logic        rd_vld = 1'b0;
    logic [7:0]  rd_byte = 8'h00;
    logic        rd_nack = 1'b0;
    logic        reg_we;
    logic [9:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic        host_busy;
    logic        done_irq;
    logic        err_irq;
    logic        bus_force_low;

    always #2.5 clk = ~clk;

    eeprom_boot_seq dut (
        .clk(clk), .rst(rst), .boot_en(boot_en), .cal_done(cal_done),
        .err_clr(err_clr), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_cnt(rd_cnt), .rd_fast(rd_fast), .rd_vld(rd_vld),
        .rd_byte(rd_byte), .rd_nack(rd_nack), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .host_busy(host_busy),
        .done_irq(done_irq), .err_irq(err_irq), .bus_force_low(bus_force_low)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] img   [0:1023];
    logic [7:0] shadow[0:1023];
    int fm[0:3];            // per attempt: 0 ok, 1 speed nack, 2 image nack, 3 bad crc
    int attempts, req_total, wr_cnt, busy_drop, spd_fast_bad;
    logic last_img_fast;
    int last_img_cnt, bad_addr;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc(input int upto);
        logic [7:0] c = 8'h00;
        for (int a = 0; a < upto; a++) begin
            c = c ^ img[a];
            for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        end
        return c;
    endfunction

    task automatic make_image(input bit fast_bit);
        for (int a = 0; a < IMG_N; a++) begin
            img[a] = (a >= 'h200 && a < 'h260) ? 8'h00 : 8'($urandom);
        end
        img[1][7] = fast_bit;
        img[CRC_OFS] = ref_crc(CRC_OFS);
    endtask

    // Monitor: register writes and host busy while bytes flow.
    always @(negedge clk) begin
        if (!rst && reg_we) begin
            shadow[reg_addr] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (!rst && rd_vld && !host_busy) busy_drop <= busy_drop + 1;
    end

    // Bus master and EEPROM model.
    initial begin
        forever begin
            @(negedge clk);
            rd_vld  = 1'b0;
            rd_nack = 1'b0;
            if (!rst && rd_req) begin
                int cnt, base, mode, nack_at;
                bit spd;
                cnt  = int'(rd_cnt);
                base = int'(rd_addr);
                spd  = (cnt == 2);
                req_total++;
                if (base != 0) bad_addr++;
                if (spd) begin
                    attempts++;
                    wr_cnt = 0;
                    if (rd_fast) spd_fast_bad++;
                end else begin
                    last_img_fast = rd_fast;
                    last_img_cnt  = cnt;
                end
                mode = fm[(attempts > 0 ? attempts - 1 : 0) > 3 ? 3 : attempts - 1];
                nack_at = -1;
                if (spd && mode == 1)  nack_at = int'($urandom_range(0, 1));
                if (!spd && mode == 2) nack_at = int'($urandom_range(0, IMG_N - 1));
                for (int i = 0; i < cnt; i++) begin
                    @(negedge clk);
                    rd_vld = 1'b0;
                    repeat ($urandom_range(0, 2)) @(negedge clk);
                    if (i == nack_at) begin
                        rd_nack = 1'b1;
                        break;
                    end
                    rd_vld  = 1'b1;
                    rd_byte = img[base + i];
                    if (!spd && mode == 3 && i == CRC_OFS) rd_byte = ~img[base + i];
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        attempts = 0; req_total = 0; wr_cnt = 0; busy_drop = 0;
        spd_fast_bad = 0; last_img_cnt = 0; last_img_fast = 1'b0; bad_addr = 0;
        for (int a = 0; a < 1024; a++) shadow[a] = 8'hxx;
        rst = 1'b0;
    endtask

    task automatic run_boot(input bit fast_bit, input int m0, input int m1,
                            input int m2, input int m3);
        fm[0] = m0; fm[1] = m1; fm[2] = m2; fm[3] = m3;
        make_image(fast_bit);
        boot_en = 1'b1; cal_done = 1'b0;
        do_reset();
        @(negedge clk);
        chk(host_busy == 1'b1, "R1 busy while pending", host_busy, 1);
        cal_done = 1'b1;
        for (int t = 0; t < 40000; t++) begin
            @(negedge clk);
            if (done_irq || err_irq) break;
        end
        repeat (60) @(negedge clk);
    endtask

    task automatic check_image(input string tag);
        int miss = 0;
        for (int a = 0; a < IMG_N; a++) if (shadow[a] !== img[a]) miss++;
        chk(miss == 0, tag, miss, 0);
        chk(wr_cnt == IMG_N, "R4 write count of last attempt", wr_cnt, IMG_N);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        fm[0] = 0; fm[1] = 0; fm[2] = 0; fm[3] = 0;

        // Reset state and gating of the boot start.
        boot_en = 1'b1; cal_done = 1'b0;
        do_reset();
        @(negedge clk);
        chk(!done_irq && !err_irq && !bus_force_low && !reg_we,
            "R1 reset flags", {done_irq, err_irq, bus_force_low, reg_we}, 0);
        repeat (50) @(negedge clk);
        chk(req_total == 0, "R1 no request without calibration", req_total, 0);
        boot_en = 1'b0; cal_done = 1'b1;
        do_reset();
        repeat (50) @(negedge clk);
        chk(req_total == 0, "R1 no request without boot mode", req_total, 0);
        chk(host_busy == 1'b0, "R1 host free without boot mode", host_busy, 0);

        // Clean boot at the fast rate.
        run_boot(1'b1, 0, 0, 0, 0);
        chk(done_irq && !err_irq, "R9 done after clean boot", {done_irq, err_irq}, 2);
        chk(!bus_force_low, "R9 bus released", bus_force_low, 0);
        chk(attempts == 1, "R6 single attempt", attempts, 1);
        chk(req_total == 2, "R9 no extra requests", req_total, 2);
        chk(spd_fast_bad == 0 && bad_addr == 0, "R2 speed phase slow at offset 0",
            spd_fast_bad + bad_addr, 0);
        chk(last_img_fast == 1'b1, "R3 fast rate selected", last_img_fast, 1);
        chk(last_img_cnt == IMG_N, "R3 image length", last_img_cnt, IMG_N);
        check_image("R4 R5 register contents");
        chk(busy_drop == 0, "R10 busy during boot", busy_drop, 0);
        chk(host_busy == 1'b0, "R10 host free after done", host_busy, 1'b0);

        // Clean boot at the slow rate.
        run_boot(1'b0, 0, 0, 0, 0);
        chk(last_img_fast == 1'b0, "R3 slow rate selected", last_img_fast, 0);
        chk(done_irq == 1'b1, "R5 crc accepted", done_irq, 1);
        check_image("R4 slow image contents");

        // Three failures of mixed kinds, then success on the last allowed try.
        for (int k = 0; k < 4; k++) begin
            int a = int'($urandom_range(1, 3));
            int b = int'($urandom_range(1, 3));
            run_boot(k[0], (k == 0) ? 1 : a, (k == 1) ? 2 : b, 3, 0);
            chk(attempts == 4, "R6 R7 attempts before success", attempts, 4);
            chk(done_irq && !err_irq, "R7 success within budget", {done_irq, err_irq}, 2);
            chk(last_img_fast == k[0], "R3 rate after retries", last_img_fast, k[0]);
            check_image("R6 image after retries");
            chk(spd_fast_bad == 0, "R2 every speed phase slow", spd_fast_bad, 0);
        end

        // One corrupted checksum then success.
        run_boot(1'b1, 3, 0, 0, 0);
        chk(attempts == 2 && done_irq, "R5 R6 crc mismatch retried", attempts, 2);

        // Four failures: abort.
        run_boot(1'b0, 2, 3, 1, 3);
        chk(attempts == 4, "R7 attempts before abort", attempts, 4);
        chk(err_irq && !done_irq, "R7 error flag", {done_irq, err_irq}, 1);
        chk(bus_force_low == 1'b1, "R8 bus held low", bus_force_low, 1);
        chk(host_busy == 1'b0, "R10 host free after abort", host_busy, 0);
        chk(req_total == 7, "R7 no request after abort", req_total, 7);
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        chk(!err_irq && !bus_force_low, "R8 clear releases bus",
            {err_irq, bus_force_low}, 0);
        repeat (50) @(negedge clk);
        chk(req_total == 7 && !done_irq, "R8 no reboot after clear", req_total, 7);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule